// File: doc/BRIEF.md
# Retriggerable Digital One-Shot Pulse Generator

This block produces a single output pulse whose length is a programmed number of clock cycles. It takes the place of a resistor-capacitor timed monostable: the timing network becomes a 16-bit width value presented on a configuration port, and the analog trigger inputs become three asynchronous digital inputs. The first is a falling-edge trigger. The second is a rising-edge trigger. The third is an active-low clear.

Each trigger is gated by the levels of the other two inputs. A trigger that arrives while the pulse is running reloads the full count, so a steady stream of triggers keeps the output high without a gap. Pulling the clear input low ends the pulse and holds off all triggering. When the clear input is released while the other two inputs sit in their armed state, that release fires a pulse by itself. All three inputs are resynchronised before any edge is taken from them. As a result, every trigger and every clear acts on the output a fixed three cycles after the input changes.

Top module: `retrig_pulse_gen`

## Requirements
- R1: While reset is asserted and after it is released, pulseOut and busy are 0 and pulseOutN is 1, and no pulse is active.
- R2: A falling edge on fallTrigN while riseTrig is 1 and clearN is 1 starts a pulse. pulseOut goes to 1 on the third rising clock edge after the input changes.
- R3: A rising edge on riseTrig while fallTrigN is 0 and clearN is 1 starts a pulse with the same three-cycle latency.
- R4: A rising edge on clearN while fallTrigN is 0 and riseTrig is 1 starts a pulse with the same three-cycle latency.
- R5: A falling edge on fallTrigN while riseTrig is 0 starts no pulse. A rising edge on riseTrig while fallTrigN is 1 starts no pulse.
- R6: With widthCfg = N and N > 0, pulseOut stays 1 for exactly N clock cycles. A trigger while widthCfg = 0 starts no pulse.
- R7: A valid trigger while pulseOut is 1 reloads the full count from widthCfg, and pulseOut stays 1 with no low cycle in between.
- R8: widthCfg is sampled only on the cycle a trigger is accepted. Changing it during a pulse does not alter that pulse's length.
- R9: clearN going to 0 drives pulseOut to 0 three cycles after the input changes. While clearN stays 0, edges on the other two inputs start no pulse. A clear takes priority over a trigger seen in the same cycle.
- R10: pulseOutN is always the complement of pulseOut, and busy always equals pulseOut.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fallTrigN | input | 1 | Asynchronous trigger, active on falling edge |
| riseTrig | input | 1 | Asynchronous trigger, active on rising edge |
| clearN | input | 1 | Asynchronous active-low clear; its rising edge also triggers |
| widthCfg | input | 16 | Pulse length in clock cycles, sampled at trigger |
| pulseOut | output | 1 | Pulse output, high while the count runs |
| pulseOutN | output | 1 | Complement of pulseOut |
| busy | output | 1 | Status bit mirroring pulseOut |

## Verification
The main function is tried with each of the three trigger routes and with widths of 0, 1 and several larger values. This separates a wrong start latency from a wrong length and from an off-by-one in the count. Each trigger is also tried with its gating input in the blocking state. That shows whether the gating levels are honoured or whether edges are taken without qualification. Directed cases then cover four more behaviours: a retrigger during a pulse, which tells a reload apart from a free-running count; a width change during a pulse, which tells sampling at trigger time apart from live use of the width; a clear in mid-pulse; and edges applied while the clear is held low.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef struct packed {
    logic load;
    logic clear;
  } ctrlStrobes_t;
endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= asyncIn;
      end
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         fallTrigN,
  input  logic         riseTrig,
  input  logic         clearN,
  output ctrlStrobes_t strobes
);
  logic fallS, riseS, clrS;
  logic fallPrev, risePrev, clrPrev;

  oneshot_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) syncFall_i (
    .clk(clk), .rstN(rstN), .asyncIn(fallTrigN), .syncOut(fallS));
  oneshot_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) syncRise_i (
    .clk(clk), .rstN(rstN), .asyncIn(riseTrig), .syncOut(riseS));
  oneshot_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) syncClr_i (
    .clk(clk), .rstN(rstN), .asyncIn(clearN), .syncOut(clrS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fallPrev <= 1'b1;
      risePrev <= 1'b0;
      clrPrev  <= 1'b1;
    end else begin
      fallPrev <= fallS;
      risePrev <= riseS;
      clrPrev  <= clrS;
    end
  end

  logic fallEdge, riseEdge, clrEdge;
  logic armedLevels;

  always_comb begin
    // Both triggers see the same armed state: falling input low, rising input high.
    armedLevels = !fallS && riseS;
    fallEdge    = fallPrev && !fallS && riseS && clrS;
    riseEdge    = !risePrev && riseS && !fallS && clrS;
    clrEdge     = !clrPrev && clrS && armedLevels;
    strobes.clear = !clrS;
    strobes.load  = (fallEdge || riseEdge || clrEdge) && clrS;
  end
endmodule

// File: rtl/oneshot_dp.sv
module oneshot_dp
  import oneshot_pkg::*;
#(
  parameter int WIDTH_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [WIDTH_BITS-1:0] widthCfg,
  output logic                  pulse
);
  logic [WIDTH_BITS-1:0] count;
  logic                  acceptLoad;

  assign acceptLoad = strobes.load && (widthCfg != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                count <= '0;
    else if (strobes.clear)   count <= '0;
    else if (acceptLoad)      count <= widthCfg;
    else if (count != '0)     count <= count - 1'b1;
  end

  assign pulse = (count != '0);

  AST_CLEAR_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (count == '0)); // R9

  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.clear && strobes.load && widthCfg != '0) |=> (count == $past(widthCfg))); // R7

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.clear && !strobes.load && count != '0) |=> (count == $past(count) - 1'b1)); // R6

  AST_END_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulse) |-> ($past(strobes.clear) || $past(count) == 1)); // R6
endmodule

// File: rtl/retrig_pulse_gen.sv
module retrig_pulse_gen
  import oneshot_pkg::*;
#(
  parameter int WIDTH_BITS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  fallTrigN,
  input  logic                  riseTrig,
  input  logic                  clearN,
  input  logic [WIDTH_BITS-1:0] widthCfg,
  output logic                  pulseOut,
  output logic                  pulseOutN,
  output logic                  busy
);
  ctrlStrobes_t strobes;
  logic         pulse;

  oneshot_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .fallTrigN(fallTrigN), .riseTrig(riseTrig),
    .clearN(clearN), .strobes(strobes));

  oneshot_dp #(.WIDTH_BITS(WIDTH_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .widthCfg(widthCfg),
    .pulse(pulse));

  assign pulseOut  = pulse;
  assign pulseOutN = !pulse;
  assign busy      = pulse;

  AST_TRIG_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(clearN, 3) && !$past(clearN, 2)) |-> !$rose(pulseOut)); // R9
endmodule

// File: tb/retrig_pulse_gen_tb_top.sv
module retrig_pulse_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fallTrigN = 1'b1;
  logic        riseTrig = 1'b0;
  logic        clearN = 1'b1;
  logic [15:0] widthCfg = 16'd0;
  logic        pulseOut, pulseOutN, busy;

  int checks = 0;
  int failures = 0;
  int mirrorBad = 0;

  always #4 clk = ~clk;

  retrig_pulse_gen dut_i (
    .clk(clk), .rstN(rstN), .fallTrigN(fallTrigN), .riseTrig(riseTrig),
    .clearN(clearN), .widthCfg(widthCfg), .pulseOut(pulseOut),
    .pulseOutN(pulseOutN), .busy(busy));

  // R10 monitor: complement and mirror at every sample point
  always @(negedge clk) begin
    if (pulseOutN !== ~pulseOut || busy !== pulseOut) mirrorBad++;
  end

  // vector: {kind[2:0], width[15:0], expected length[15:0]}
  // kind 0 falling trigger, 1 rising trigger, 2 clear release,
  // 3 falling trigger gated off, 4 rising trigger gated off
  localparam int NVEC = 9;
  localparam logic [34:0] VECS [0:NVEC-1] = '{
    {3'd0, 16'd5,  16'd5},
    {3'd1, 16'd1,  16'd1},
    {3'd2, 16'd7,  16'd7},
    {3'd0, 16'd0,  16'd0},
    {3'd3, 16'd5,  16'd0},
    {3'd4, 16'd5,  16'd0},
    {3'd1, 16'd12, 16'd12},
    {3'd2, 16'd2,  16'd2},
    {3'd0, 16'd33, 16'd33}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Move to a quiet input state without creating a trigger.
  task automatic setIdle(input logic a, input logic b, input logic c);
    clearN = 1'b0;
    waitCycles(4);
    fallTrigN = a;
    riseTrig = b;
    waitCycles(4);
    clearN = c;
    waitCycles(6);
  endtask

  // Returns sample index of first high (-1 if none) and run length.
  task automatic measure(output int lat, output int len);
    lat = -1;
    len = 0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (pulseOut) begin
        lat = i;
        break;
      end
    end
    if (lat > 0) begin
      len = 1;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (!pulseOut) break;
        len++;
      end
    end
  endtask

  function automatic string kindReq(input logic [2:0] k);
    case (k)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat, len;
    logic [2:0]  kind;
    logic [15:0] w, expLen;

    // R1: reset state
    waitCycles(3);
    check(pulseOut == 1'b0 && pulseOutN == 1'b1 && busy == 1'b0, "R1", pulseOut, 0);
    rstN = 1'b1;
    waitCycles(4);
    check(pulseOut == 1'b0 && busy == 1'b0, "R1", pulseOut, 0);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      kind   = VECS[v][34:32];
      w      = VECS[v][31:16];
      expLen = VECS[v][15:0];
      widthCfg = w;
      case (kind)
        3'd0: setIdle(1'b1, 1'b1, 1'b1);
        3'd1: setIdle(1'b0, 1'b0, 1'b1);
        3'd2: setIdle(1'b0, 1'b1, 1'b0);
        3'd3: setIdle(1'b1, 1'b0, 1'b1);
        default: setIdle(1'b1, 1'b0, 1'b1);
      endcase
      check(pulseOut == 1'b0, "R1", pulseOut, 0);
      case (kind)
        3'd0, 3'd3: fallTrigN = 1'b0;
        3'd1, 3'd4: riseTrig = 1'b1;
        default:    clearN = 1'b1;
      endcase
      measure(lat, len);
      if (expLen == 0) begin
        check(lat == -1, (w == 0) ? "R6" : kindReq(kind), lat, -1);
      end else begin
        check(lat == 3, kindReq(kind), lat, 3);
        check(len == int'(expLen), "R6", len, int'(expLen));
      end
    end

    // R7: retrigger during a pulse reloads with no gap
    widthCfg = 16'd10;
    setIdle(1'b1, 1'b1, 1'b1);
    fallTrigN = 1'b0;
    measure(lat, len);
    check(len == 10, "R7", len, 10);
    setIdle(1'b1, 1'b1, 1'b1);
    fallTrigN = 1'b0;
    waitCycles(3);
    check(pulseOut == 1'b1, "R7", pulseOut, 1);
    waitCycles(4);
    fallTrigN = 1'b1;
    waitCycles(2);
    fallTrigN = 1'b0;           // sample index 6 after first high
    len = 7;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!pulseOut) break;
      len++;
    end
    check(len == 19, "R7", len, 19);

    // R8: width changed mid-pulse has no effect
    widthCfg = 16'd4;
    setIdle(1'b1, 1'b1, 1'b1);
    fallTrigN = 1'b0;
    waitCycles(3);
    widthCfg = 16'd20;
    len = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!pulseOut) break;
      len++;
    end
    check(len == 4, "R8", len, 4);

    // R9: clear in mid-pulse
    widthCfg = 16'd20;
    setIdle(1'b1, 1'b1, 1'b1);
    fallTrigN = 1'b0;
    waitCycles(5);              // first high at 3, now at index 2
    clearN = 1'b0;
    waitCycles(2);
    check(pulseOut == 1'b1, "R9", pulseOut, 1);
    waitCycles(1);
    check(pulseOut == 1'b0, "R9", pulseOut, 0);

    // R9: triggers blocked while clear is held low
    fallTrigN = 1'b1;
    riseTrig = 1'b1;
    waitCycles(5);
    fallTrigN = 1'b0;           // would be a valid falling trigger
    waitCycles(8);
    riseTrig = 1'b0;
    waitCycles(4);
    riseTrig = 1'b1;            // would be a valid rising trigger
    waitCycles(8);
    check(pulseOut == 1'b0, "R9", pulseOut, 0);
    fallTrigN = 1'b1;
    waitCycles(4);
    clearN = 1'b1;
    waitCycles(6);
    check(pulseOut == 1'b0, "R9", pulseOut, 0);

    // R10: complement and mirror over the whole run
    check(mirrorBad == 0, "R10", mirrorBad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule